// File: doc/BRIEF.md
# Code-Selected Programmable Clock Divider

This block divides a fast reference clock down to two output clocks. Each output has its own 4-bit ratio code. The code has two fields. The upper two bits choose a small base ratio, which may be odd. The lower two bits multiply that base by 1, 2, 4 or 8. A build-time parameter selects one of two base tables. Odd ratios still give a 50% duty cycle. To do this, a rising-edge counter output is combined with a copy of that output retimed on the falling edge.

Software-style control comes through a one-byte write port with a single address bit. Address 0 holds both ratio codes. Address 1 holds one phase-inversion bit per output. While reset is held, the ratio byte is loaded from a strap input. A new code or a new inversion setting waits until the current output period has finished before it takes effect, so the outputs never carry runt pulses.

Top module: `ratio_code_divider`

## Requirements
- R1: With ALT_TABLE=0 the division ratio of a code is B shifted left by code[1:0], where code[3:2] selects B as 00→2, 01→3, 10→5, 11→7; the output period is that many reference cycles.
- R2: With ALT_TABLE=1 the base table is 00→4, 01→3, 10→5, 11→9, with the same power-of-two scaling from code[1:0], so ratios range from 3 to 72.
- R3: For every ratio N, the output is high for exactly N reference half-cycles and low for N half-cycles, including odd N.
- R4: A write with wr_addr=0 loads the ratio byte. Bits [7:4] set the code of div_out[1] and bits [3:0] set the code of div_out[0].
- R5: A write with wr_addr=1 loads the inversion bits. Bit 1 inverts div_out[1] and bit 0 inverts div_out[0]. An inverted output is the exact complement of the non-inverted waveform.
- R6: While rst_n is low, the ratio byte takes the value on strap_code, and the inversion bits clear. After release, the outputs divide by the ratios given by the strap.
- R7: While rst_n is low, both outputs are low. On the first rising reference edge after release, an output with an even ratio goes high.
- R8: A ratio or inversion written in the middle of an output period does not change that period. The new setting starts with the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_code | input | 8 | Reset value of the ratio byte |
| wr_en | input | 1 | Byte write strobe, sampled on the rising edge |
| wr_addr | input | 1 | 0 selects the ratio byte, 1 selects the inversion bits |
| wr_data | input | 8 | Write data |
| div_out | output | 2 | Divided clocks; bit 1 follows the upper nibble, bit 0 the lower |

## Verification
The assertions assume that wr_en, wr_addr and wr_data change only between rising reference edges. They also assume that rst_n is released away from a rising edge. The bench therefore drives every write a quarter cycle after a rising edge and holds it for one full cycle, and it releases reset on a falling edge. The bench measures every waveform by sampling a quarter cycle after each reference edge of either polarity. This gives half-cycle resolution with no race at any edge, which the odd-ratio duty checks require.

// File: rtl/ratio_code_divider.sv
`timescale 1ns/1ps
module ratio_code_divider #(
  parameter bit ALT_TABLE = 1'b0
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic [7:0] strap_code,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  output logic [1:0] div_out
);

  localparam int NCH    = 2;
  localparam int CODE_W = 4;
  localparam int MAX_N  = 72;
  localparam int CW     = $clog2(MAX_N + 1);

  function automatic logic [CW-1:0] ratio_of(input logic [CODE_W-1:0] c);
    logic [CW-1:0] b;
    case (c[3:2])
      2'b00:   b = ALT_TABLE ? CW'(4) : CW'(2);
      2'b01:   b = CW'(3);
      2'b10:   b = CW'(5);
      default: b = ALT_TABLE ? CW'(9) : CW'(7);
    endcase
    return b << c[1:0];
  endfunction

  logic [7:0]        ratio_q;
  logic [NCH-1:0]    inv_q;
  logic              start_q;
  logic [NCH*CW-1:0] cnt_all;
  logic [NCH*CW-1:0] len_all;
  logic [NCH-1:0]    rise_all;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= strap_code;
      inv_q   <= '0;
      start_q <= 1'b1;
    end else begin
      start_q <= 1'b0;
      if (wr_en && !wr_addr) ratio_q <= wr_data;
      if (wr_en &&  wr_addr) inv_q   <= wr_data[NCH-1:0];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CW-1:0] cnt_q, len_q, next_len, hi_len;
    logic          rise_q, fall_q, odd_q, inv_act, wrap;

    assign next_len = ratio_of(ratio_q[CODE_W*i +: CODE_W]);
    assign hi_len   = (len_q + CW'(1)) >> 1;
    assign wrap     = start_q || (cnt_q == len_q - CW'(1));

    always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q   <= '0;
        len_q   <= ratio_of(strap_code[CODE_W*i +: CODE_W]);
        rise_q  <= 1'b0;
        odd_q   <= 1'b0;
        inv_act <= 1'b0;
      end else if (wrap) begin
        cnt_q   <= '0;
        len_q   <= next_len;
        odd_q   <= next_len[0];
        inv_act <= inv_q[i];
        rise_q  <= 1'b1;
      end else begin
        cnt_q   <= cnt_q + CW'(1);
        rise_q  <= (cnt_q + CW'(1)) < hi_len;
      end
    end

    always_ff @(negedge clk_ref or negedge rst_n) begin
      if (!rst_n) fall_q <= 1'b0;
      else        fall_q <= rise_q;
    end

    assign div_out[i] = (rise_q & (fall_q | ~odd_q)) ^ inv_act;
    assign cnt_all[CW*i +: CW] = cnt_q;
    assign len_all[CW*i +: CW] = len_q;
    assign rise_all[i] = rise_q;
  end

endmodule

module ratio_code_divider_chk #(
  parameter int CW = 7
) (
  input logic          clk_ref,
  input logic          rst_n,
  input logic          wr_en,
  input logic          wr_addr,
  input logic [7:0]    wr_data,
  input logic [7:0]    ratio_q,
  input logic [1:0]    inv_q,
  input logic [2*CW-1:0] cnt_all,
  input logic [2*CW-1:0] len_all,
  input logic [1:0]    rise_all
);

  assert_load_ratio_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (wr_en && !wr_addr) |=> ratio_q == $past(wr_data));

  assert_load_inv_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (wr_en && wr_addr) |=> inv_q == $past(wr_data[1:0]));

  assert_count_bound_R1: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (cnt_all[CW-1:0] < len_all[CW-1:0]) && (cnt_all[2*CW-1:CW] < len_all[2*CW-1:CW]));

  assert_len_at_wrap0_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (len_all[CW-1:0] != $past(len_all[CW-1:0])) |-> cnt_all[CW-1:0] == '0);

  assert_len_at_wrap1_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (len_all[2*CW-1:CW] != $past(len_all[2*CW-1:CW])) |-> cnt_all[2*CW-1:CW] == '0);

  assert_rise_at_start_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(rise_all[0]) |-> cnt_all[CW-1:0] == '0);

endmodule

bind ratio_code_divider ratio_code_divider_chk #(.CW(CW)) u_chk (.*);

// File: tb/ratio_code_divider_test.sv
`timescale 1ns/1ps
module ratio_code_divider_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] strap = 8'h21;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] out_a, out_b;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ratio_code_divider #(.ALT_TABLE(1'b0)) uut (
    .clk_ref(clk), .rst_n(rst_n), .strap_code(strap), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .div_out(out_a));

  ratio_code_divider #(.ALT_TABLE(1'b1)) uut_alt (
    .clk_ref(clk), .rst_n(rst_n), .strap_code(strap), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .div_out(out_b));

  function automatic int exp_ratio(input bit alt, input int code);
    int b;
    case ((code >> 2) & 3)
      0: b = alt ? 4 : 2;
      1: b = 3;
      2: b = 5;
      default: b = alt ? 9 : 7;
    endcase
    return b << (code & 3);
  endfunction

  function automatic bit pick(input bit alt, input int ch);
    return alt ? out_b[ch] : out_a[ch];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk or negedge clk);
    #1.25;
  endtask

  task automatic wr(input bit addr, input logic [7:0] data);
    @(posedge clk); #1.25;
    wr_en = 1'b1; wr_addr = addr; wr_data = data;
    @(posedge clk); #1.25;
    wr_en = 1'b0;
  endtask

  task automatic measure(input bit alt, input int ch, output int hi, output int per);
    bit prev, v;
    int n = 0, rises = 0;
    prev = pick(alt, ch);
    v = prev;
    while (rises < 2 && n < 4000) begin
      tick(); v = pick(alt, ch);
      if (!prev && v) rises++;
      prev = v; n++;
    end
    hi = 0; per = 0;
    while (v && n < 4000) begin hi++; per++; tick(); v = pick(alt, ch); n++; end
    while (!v && n < 4000) begin per++; tick(); v = pick(alt, ch); n++; end
  endtask

  task automatic do_reset(input logic [7:0] s, input bit first_high);
    rst_n = 1'b0;
    strap = s;
    repeat (3) @(posedge clk);
    #1.25;
    check("R7 outputs low in reset", {out_a, out_b}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1.25;
    if (first_high) check("R7 rise on first edge", {out_a, out_b}, 4'hF);
  endtask

  task automatic test_strap();
    int hi, per;
    do_reset(8'h21, 1'b1);
    measure(1'b0, 1, hi, per); check("R6 strap uut ch1 period", per, 16);
    measure(1'b0, 0, hi, per); check("R6 strap uut ch0 period", per, 8);
    measure(1'b1, 1, hi, per); check("R6 strap alt ch1 period", per, 32);
    measure(1'b1, 0, hi, per); check("R6 strap alt ch0 period", per, 16);
  endtask

  task automatic test_sweep();
    int hi, per, n;
    for (int code = 0; code < 16; code++) begin
      wr(1'b0, 8'((code << 4) | code));
      n = exp_ratio(1'b0, code);
      measure(1'b0, 0, hi, per);
      check("R1 period", per, 2 * n);
      check("R3 high time", hi, n);
      measure(1'b0, 1, hi, per);
      check("R4 upper nibble period", per, 2 * n);
      n = exp_ratio(1'b1, code);
      measure(1'b1, 0, hi, per);
      check("R2 alt period", per, 2 * n);
      check("R3 alt high time", hi, n);
    end
  endtask

  task automatic test_nibble_map();
    int hi, per;
    wr(1'b0, 8'h4C);
    measure(1'b0, 1, hi, per); check("R4 upper nibble code 4", per, 6);
    measure(1'b0, 0, hi, per); check("R4 lower nibble code C", per, 14);
    check("R3 ratio 7 high time", hi, 7);
  endtask

  task automatic test_invert(input int code);
    int hi, per, n, mism;
    n = exp_ratio(1'b0, code);
    do_reset(8'((code << 4) | code), 1'b0);
    wr(1'b1, 8'h02);
    repeat (4 * n + 8) tick();
    mism = 0;
    for (int k = 0; k < 4 * n; k++) begin
      if (out_a[1] !== ~out_a[0]) mism++;
      tick();
    end
    check("R5 inverted is complement", mism, 0);
    measure(1'b0, 1, hi, per);
    check("R5 inverted period", per, 2 * n);
    check("R5 inverted high time", hi, n);
  endtask

  task automatic test_glitch();
    bit prev, v;
    int n = 0, k = 0, hi = 0, per = 0, hi2, per2;
    do_reset(8'hFF, 1'b0);
    prev = out_a[0]; v = prev;
    while (!(!prev && v) && n < 4000) begin
      prev = v; tick(); v = out_a[0]; n++;
    end
    while (v && n < 4000) begin
      if (k == 10) begin wr_en = 1'b1; wr_addr = 1'b0; wr_data = 8'h00; end
      if (k == 12) wr_en = 1'b0;
      hi++; per++; k++; tick(); v = out_a[0]; n++;
    end
    while (!v && n < 4000) begin per++; tick(); v = out_a[0]; n++; end
    check("R8 old period high kept", hi, 56);
    check("R8 old period length kept", per, 112);
    measure(1'b0, 0, hi2, per2);
    check("R8 new ratio applied", per2, 4);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    test_strap();
    test_sweep();
    test_nibble_map();
    test_invert(4);
    test_invert(9);
    test_glitch();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule